// File: doc/BRIEF.md
# Comma Detect Word Framer

This block turns a raw serial 8B/10B bit stream into aligned ten-bit transmission characters. One bit arrives per bit clock and is shifted into a ten-bit window. A free-running bit counter marks every tenth bit as a character boundary. At each boundary the block presents the collected character on a parallel output together with a one-cycle strobe.

Alignment is changed only while the reframe enable input is high. In that state the window is compared, bit by bit as it arrives, against both running-disparity forms of the K28.5 sync character. On a match the matched character is presented at once with a strobe, and the bit counter restarts so that the next ten bits form the next character. The ready output drops for one character time to mark the new boundary. While reframe is low, comma patterns in the stream are only data, and the counter keeps its modulo-ten cadence.

Top module: `commaWordFramer`

## Requirements
- R1: With reframe low, charStrobe pulses for exactly one cycle after every tenth bit clock, and the cadence is independent of the data.
- R2: The first bit received for a character appears on charOut[0] and the last on charOut[9]. The serial order a,b,c,d,e,i,f,g,h,j maps to indices 0 through 9, and charOut holds its value between strobes.
- R3: With reframe low, a K28.5 pattern at any bit offset neither moves the strobe cadence nor lowers ready.
- R4: With reframe high, the arrival of the last bit of 10'h17C or 10'h283 (both given with index 0 = bit a) pulses charStrobe with charOut equal to that pattern, whatever the previous phase. The next strobe follows exactly ten bits later.
- R5: Ready falls on the same cycle as the strobe of a detected sync and stays low for ten cycles. A further detection within that time restarts the ten cycles. Ready is high at all other times.
- R6: A synchronous reset clears the window, charOut and charStrobe, sets ready high and restarts the count, so the first strobe follows the tenth bit after reset.
- R7: With reframe high, a ten-bit window that equals neither sync form causes no realignment and no fall of ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| serialBit | input | 1 | Received serial bit |
| reframeEn | input | 1 | Allows realignment on a sync character |
| charOut | output | 10 | Aligned character, index 0 = first bit received |
| charStrobe | output | 1 | One-cycle pulse when charOut is updated |
| ready | output | 1 | Low for one character time after a sync alignment |

## Verification
The bench builds the block with its default ten-bit character and the two K28.5 forms as the sync set. That configuration is small enough to sweep every bit offset 0 through 9 for each sync form, with reframe both high and low. It is also small enough to walk a single set bit through all ten character positions. A bench-side arithmetic model of the boundary count, window and ready timer is compared every bit against long pseudo-random streams, including streams where a sync arrives while ready is already low.

// File: rtl/framer_pkg.sv
package framer_pkg;

  // K28.5 in both disparities, index 0 = first serial bit (a)
  localparam logic [9:0] SYNC_RD_NEG = 10'h17C;
  localparam logic [9:0] SYNC_RD_POS = 10'h283;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture; // load the incoming window into the output register
    logic align;   // sync hit accepted, boundary moved here
  } framerCtrl_t;

endpackage

// File: rtl/framerDatapath.sv
module framerDatapath
  import framer_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int NUM_SYNC = 2,
  parameter logic [NUM_SYNC*CHAR_W-1:0] SYNC_SET = {SYNC_RD_POS, SYNC_RD_NEG}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialBit,
  input  framerCtrl_t       ctrl,
  output logic              matchHit,
  output logic [CHAR_W-1:0] charOut
);

  logic [CHAR_W-1:0]   shiftWin;
  logic [CHAR_W-1:0]   nextWin;
  logic [NUM_SYNC-1:0] hitVec;

  // newest bit enters at the top, first bit ends at index 0
  assign nextWin = {serialBit, shiftWin[CHAR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) shiftWin <= '0;
    else     shiftWin <= nextWin;
  end

  generate
    for (genvar g = 0; g < NUM_SYNC; g++) begin : gSyncCmp
      assign hitVec[g] = (nextWin == SYNC_SET[g*CHAR_W +: CHAR_W]);
    end
  endgenerate

  assign matchHit = |hitVec;

  always_ff @(posedge clk) begin
    if (rst)              charOut <= '0;
    else if (ctrl.capture) charOut <= nextWin;
  end

  function automatic logic isSync(input logic [CHAR_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_SYNC; k++)
      if (v == SYNC_SET[k*CHAR_W +: CHAR_W]) r = 1'b1;
    return r;
  endfunction

  AST_SYNC_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    ctrl.align |=> isSync(charOut)); // R4

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(charOut)); // R2

endmodule

// File: rtl/framerControl.sv
module framerControl
  import framer_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reframeEn,
  input  logic        matchHit,
  output framerCtrl_t ctrl,
  output logic        charStrobe,
  output logic        ready
);

  localparam int CNT_W = $clog2(CHAR_W);
  localparam int LOW_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);
  localparam logic [LOW_W-1:0] LOW_LEN  = LOW_W'(CHAR_W);

  logic [CNT_W-1:0] bitCnt;
  logic [LOW_W-1:0] lowCnt;

  always_comb begin
    ctrl.align   = reframeEn && matchHit;
    ctrl.capture = ctrl.align || (bitCnt == LAST_BIT);
  end

  // boundary counter: bits gathered so far in the current character
  always_ff @(posedge clk) begin
    if (rst)               bitCnt <= '0;
    else if (ctrl.capture) bitCnt <= '0;
    else                   bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) charStrobe <= 1'b0;
    else     charStrobe <= ctrl.capture;
  end

  // ready timer: one character time low per accepted sync
  always_ff @(posedge clk) begin
    if (rst)                 lowCnt <= '0;
    else if (ctrl.align)     lowCnt <= LOW_LEN;
    else if (lowCnt != '0)   lowCnt <= lowCnt - 1'b1;
  end

  assign ready = (lowCnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LAST_BIT); // R1

  AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (rst)
    charStrobe |-> (bitCnt == '0)); // R4

  AST_READY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> charStrobe); // R5

  AST_ALIGN_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(reframeEn)); // R3

endmodule

// File: rtl/commaWordFramer.sv
module commaWordFramer
  import framer_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int NUM_SYNC = 2,
  parameter logic [NUM_SYNC*CHAR_W-1:0] SYNC_SET = {SYNC_RD_POS, SYNC_RD_NEG}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialBit,
  input  logic              reframeEn,
  output logic [CHAR_W-1:0] charOut,
  output logic              charStrobe,
  output logic              ready
);

  framerCtrl_t ctrl;
  logic        matchHit;

  framerDatapath #(
    .CHAR_W(CHAR_W), .NUM_SYNC(NUM_SYNC), .SYNC_SET(SYNC_SET)
  ) uData (
    .clk(clk), .rst(rst), .serialBit(serialBit), .ctrl(ctrl),
    .matchHit(matchHit), .charOut(charOut)
  );

  framerControl #(.CHAR_W(CHAR_W)) uCtrl (
    .clk(clk), .rst(rst), .reframeEn(reframeEn), .matchHit(matchHit),
    .ctrl(ctrl), .charStrobe(charStrobe), .ready(ready)
  );

  AST_RESET_READY: assert property (@(posedge clk)
    $past(rst) |-> (ready && !charStrobe)); // R6

endmodule

// File: tb/tb_commaWordFramer.sv
module tb_commaWordFramer;

  localparam logic [9:0] SP = 10'h17C;
  localparam logic [9:0] SN = 10'h283;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialBit = 1'b0;
  logic       reframeEn = 1'b0;
  logic [9:0] charOut;
  logic       charStrobe;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R6";

  // bench model
  logic [9:0] mWin = '0;
  logic [9:0] mOut = '0;
  logic       mValid = 1'b0;
  int         mCnt = 0;
  int         mLow = 0;

  always #10 clk = ~clk;

  commaWordFramer dut (
    .clk(clk), .rst(rst), .serialBit(serialBit), .reframeEn(reframeEn),
    .charOut(charOut), .charStrobe(charStrobe), .ready(ready)
  );

  task automatic check(input string tag, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic sendBit(input logic b);
    logic hit;
    serialBit = b;
    mWin = {b, mWin[9:1]};
    hit = reframeEn && (mWin == SP || mWin == SN);
    if (hit || mCnt == 9) begin
      mValid = 1'b1; mOut = mWin; mCnt = 0;
    end else begin
      mValid = 1'b0; mCnt++;
    end
    if (hit) mLow = 10;
    else if (mLow > 0) mLow--;
    @(negedge clk);
    check(req, "strobe", {9'd0, charStrobe}, {9'd0, mValid});
    check(req, "ready", {9'd0, ready}, {9'd0, (mLow == 0)});
    check(req, "charOut", charOut, mOut);
  endtask

  task automatic sendChar(input logic [9:0] c);
    for (int i = 0; i < 10; i++) sendBit(c[i]);
  endtask

  task automatic doReset();
    rst = 1'b1; reframeEn = 1'b0; serialBit = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "reset strobe", {9'd0, charStrobe}, 10'd0);
    check("R6", "reset ready", {9'd0, ready}, 10'd1);
    check("R6", "reset charOut", charOut, 10'd0);
    rst = 1'b0;
    mWin = '0; mOut = '0; mValid = 1'b0; mCnt = 0; mLow = 0;
  endtask

  initial begin
    int lowSeen;
    @(negedge clk);
    doReset();

    // R6: first strobe after the tenth bit
    req = "R6";
    sendChar(10'h2A5);

    // R2: walk one set bit through each position
    req = "R2";
    for (int k = 0; k < 10; k++) begin
      sendChar(10'd1 << k);
      check("R2", "bit position", charOut, 10'd1 << k);
    end
    sendChar(SP);
    check("R2", "sync order", charOut, SP);

    // R1: free-running random data
    req = "R1";
    for (int i = 0; i < 400; i++) sendBit(1'($urandom));

    // R3: sync at every offset with reframe low
    req = "R3";
    lowSeen = 0;
    for (int off = 1; off < 10; off++) begin
      for (int i = 0; i < off; i++) sendBit(1'b0);
      sendChar((off % 2) ? SP : SN);
      for (int i = 0; i < 5; i++) begin
        sendBit(1'b0);
        if (!ready) lowSeen++;
      end
    end
    check("R3", "ready drops", 10'(lowSeen), 10'd0);

    // R4 / R5: reframe sweep over both forms and all offsets
    reframeEn = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int off = 0; off < 10; off++) begin
        req = "R4";
        for (int i = 0; i < off; i++) sendBit(1'b0);
        sendChar(d ? SN : SP);
        check("R4", "sync strobe", {9'd0, charStrobe}, 10'd1);
        check("R4", "sync out", charOut, d ? SN : SP);
        check("R5", "ready low", {9'd0, ready}, 10'd0);
        req = "R5";
        sendChar(10'h155);
        check("R4", "next boundary", {9'd0, charStrobe}, 10'd1);
        check("R5", "ready back", {9'd0, ready}, 10'd1);
      end
    end

    // R5: back-to-back syncs keep ready low
    req = "R5";
    sendChar(SP);
    lowSeen = 0;
    for (int i = 0; i < 10; i++) begin
      sendBit(SN[i]);
      if (ready) lowSeen++;
    end
    check("R5", "ready high during reload", 10'(lowSeen), 10'd0);
    sendChar(10'h155);

    // R7: near-sync and random data with reframe high
    req = "R7";
    lowSeen = 0;
    for (int k = 0; k < 10; k++) begin
      sendBit(1'b1);
      sendChar(SP ^ (10'd1 << k));
      sendChar(10'h155);
      if (!ready) lowSeen++;
    end
    check("R7", "near-sync drops", 10'(lowSeen), 10'd0);
    for (int i = 0; i < 400; i++) sendBit(1'($urandom));

    // R6: reset in mid-stream restarts the count
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    doReset();
    req = "R6";
    sendChar(10'h0F3);
    check("R6", "first char after reset", charOut, 10'h0F3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule